// File: doc/BRIEF.md
# Shift and Rotate Unit

This block is the bit-movement datapath of a CISC-style integer core. Each accepted request carries a 32-bit operand, an operand size (8, 16 or 32 bits), a shift count from 0 to 63, an operation code and the current extend flag. The block returns the moved operand together with fresh negative, zero, overflow, carry and extend flags. Only the low bits picked by the size are moved; the bits above them come back unchanged.

Eight operations are offered: logical left and right, arithmetic left and right, plain rotate left and right, and rotate left and right through the extend bit. The extend flag is held apart from carry, so a bit pushed out by one operation can be carried into a later multi-word operation without disturbing the carry used by branch tests. The whole count is applied in one cycle, and the outcome is the same as if the operand were moved one position per step.

The answer is captured in an output register the cycle after a request. A two-state controller tracks whether that register holds a fresh answer: `ST_IDLE` (nothing new) moves to `ST_LOADED` on a request; `ST_LOADED` stays there on a back-to-back request and returns to `ST_IDLE` on a cycle without one.

Top module: `shrot_unit`

## Requirements
- R1: A request (`req_valid` high at a rising edge) produces its result and flags on the outputs after that edge, with `rsp_valid` high for that one cycle; when `req_valid` is low the outputs hold their values and `rsp_valid` is low. Reset clears the result, every flag and `rsp_valid`.
- R2: `req_size` 00 selects 8 bits, 01 selects 16 bits, 10 and 11 select 32 bits; result bits above the selected size equal the operand bits.
- R3: Logical shifts (`req_op` 000 left, 001 right) fill vacated positions with zero; a count equal to or above the size gives a sized result of zero.
- R4: Arithmetic right shift (`req_op` 011) copies the sized operand's top bit into every vacated position.
- R5: Arithmetic left shift (`req_op` 010) gives the same result as the logical left shift and sets V when the sized top bit took more than one value during the step-by-step shift; every other operation clears V.
- R6: For the four shifts, C and X both take the last bit shifted out (zero once the count passes the size for logical shifts, the sign bit for the arithmetic right shift); a count of zero clears C and leaves X equal to the incoming extend flag.
- R7: Plain rotates (`req_op` 100 left, 101 right) circulate the sized bits, leave X equal to the incoming extend flag, and set C to the last bit rotated out, or clear it for a count of zero.
- R8: Rotates through extend (`req_op` 110 left, 111 right) rotate a ring of size+1 bits formed by the extend flag above the sized operand; X takes the last bit moved out and C equals the new X, so a count of zero copies the incoming extend flag to both.
- R9: N equals the top bit of the sized result and Z is set exactly when the sized result is zero.
- R10: Any count from 0 to 63 gives the same result and flags as applying the operation one position at a time, including counts that wrap a rotation ring more than once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_opnd | input | 32 | Operand |
| req_size | input | 2 | Operand size select |
| req_count | input | 6 | Shift or rotate count |
| req_op | input | 3 | Operation code |
| req_xflag | input | 1 | Incoming extend flag |
| rsp_valid | output | 1 | Fresh result on the outputs |
| rsp_result | output | 32 | Moved operand, upper bits passed through |
| rsp_n | output | 1 | Negative flag |
| rsp_z | output | 1 | Zero flag |
| rsp_v | output | 1 | Overflow flag |
| rsp_c | output | 1 | Carry flag |
| rsp_x | output | 1 | Extend flag |

## Verification
The hardest outcome to reach from the ports is the overflow of an arithmetic left shift whose sized top bit flips only after several steps or only when the count runs past the size, and the rotate-through-extend ring wrapping with a count above the ring length. Directed requests aim at these: small operands with a single set bit shifted into the top, all-ones and single-one operands shifted by exactly the size and beyond, and 8-bit rings rotated by 9, 18 and 63. A long run of random requests with random gaps then compares every cycle against a bench model that moves the operand one position per step.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [2:0] {
        OP_LSL = 3'd0,
        OP_LSR = 3'd1,
        OP_ASL = 3'd2,
        OP_ASR = 3'd3,
        OP_ROL = 3'd4,
        OP_ROR = 3'd5,
        OP_RXL = 3'd6,
        OP_RXR = 3'd7
    } shr_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_ALT  = 2'd3
    } shr_size_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_LOADED = 1'b1
    } shr_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
        logic x;
    } shr_flags_t;

    localparam int NUM_LANES = 3;

endpackage

// File: rtl/shrot_lane.sv
module shrot_lane
    import shrot_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 6
) (
    input  logic [W-1:0]     opnd,
    input  logic [CNT_W-1:0] count,
    input  logic [2:0]       op,
    input  logic             xin,
    output logic [W-1:0]     res,
    output logic             c_out,
    output logic             x_out,
    output logic             v_out
);
    localparam int RW = W + 1;

    shr_op_e op_e;
    assign op_e = shr_op_e'(op);

    logic             nz;
    logic [CNT_W-1:0] cm1;
    logic [CNT_W-1:0] krot;
    logic [CNT_W-1:0] kext;
    assign nz   = |count;
    assign cm1  = count - 1'b1;
    assign krot = CNT_W'(int'(count) % W);
    assign kext = CNT_W'(int'(count) % RW);

    logic signed [W-1:0] sv;
    assign sv = opnd;

    // shift results and the operand moved one step less (its edge bit is the last out)
    logic [W-1:0] lsl_r, lsl_p, lsr_r, lsr_p, asr_r, asr_p;
    assign lsl_r = opnd << count;
    assign lsl_p = opnd << cm1;
    assign lsr_r = opnd >> count;
    assign lsr_p = opnd >> cm1;
    assign asr_r = sv >>> count;
    assign asr_p = sv >>> cm1;

    logic [W-1:0] rol_r, ror_r;
    assign rol_r = (opnd << krot) | (opnd >> (W - int'(krot)));
    assign ror_r = (opnd >> krot) | (opnd << (W - int'(krot)));

    logic [W:0] ring, rxl_r, rxr_r;
    assign ring  = {xin, opnd};
    assign rxl_r = (ring << kext) | (ring >> (RW - int'(kext)));
    assign rxr_r = (ring >> kext) | (ring << (RW - int'(kext)));

    // overflow of the left arithmetic shift: any bit in the swept window differs from the top
    logic [W-1:0] diff;
    logic         asl_v;
    assign diff = opnd ^ {W{opnd[W-1]}};
    always_comb begin
        asl_v = 1'b0;
        if (nz) begin
            for (int i = 0; i < W; i++) begin
                if ((int'(count) >= (W - 1 - i)) && diff[i]) asl_v = 1'b1;
            end
            if ((int'(count) >= W) && opnd[W-1]) asl_v = 1'b1;
        end
    end

    always_comb begin
        res   = opnd;
        c_out = 1'b0;
        x_out = xin;
        v_out = 1'b0;
        unique case (op_e)
            OP_LSL, OP_ASL: begin
                res   = lsl_r;
                c_out = nz & lsl_p[W-1];
                x_out = nz ? lsl_p[W-1] : xin;
                v_out = (op_e == OP_ASL) ? asl_v : 1'b0;
            end
            OP_LSR: begin
                res   = lsr_r;
                c_out = nz & lsr_p[0];
                x_out = nz ? lsr_p[0] : xin;
            end
            OP_ASR: begin
                res   = asr_r;
                c_out = nz & asr_p[0];
                x_out = nz ? asr_p[0] : xin;
            end
            OP_ROL: begin
                res   = rol_r;
                c_out = nz & rol_r[0];
            end
            OP_ROR: begin
                res   = ror_r;
                c_out = nz & ror_r[W-1];
            end
            OP_RXL: begin
                res   = rxl_r[W-1:0];
                c_out = rxl_r[W];
                x_out = rxl_r[W];
            end
            OP_RXR: begin
                res   = rxr_r[W-1:0];
                c_out = rxr_r[W];
                x_out = rxr_r[W];
            end
        endcase
    end

endmodule

// File: rtl/shrot_merge.sv
module shrot_merge
    import shrot_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]                       size,
    input  logic [DATA_W-1:0]                opnd,
    input  logic [NUM_LANES-1:0][DATA_W-1:0] lane_res,
    input  logic [NUM_LANES-1:0]             lane_c,
    input  logic [NUM_LANES-1:0]             lane_x,
    input  logic [NUM_LANES-1:0]             lane_v,
    output logic [DATA_W-1:0]                result,
    output shr_flags_t                       flags
);
    localparam int BYTE_W = DATA_W / 4;
    localparam int WORD_W = DATA_W / 2;

    shr_size_e size_e;
    assign size_e = shr_size_e'(size);

    logic [1:0]        sel;
    logic [DATA_W-1:0] mask;
    logic              top;

    always_comb begin
        unique case (size_e)
            SZ_BYTE: begin
                sel  = 2'd0;
                mask = DATA_W'({BYTE_W{1'b1}});
            end
            SZ_WORD: begin
                sel  = 2'd1;
                mask = DATA_W'({WORD_W{1'b1}});
            end
            SZ_LONG, SZ_ALT: begin
                sel  = 2'd2;
                mask = {DATA_W{1'b1}};
            end
        endcase
    end

    assign result = (opnd & ~mask) | (lane_res[sel] & mask);

    always_comb begin
        unique case (sel)
            2'd0:    top = result[BYTE_W-1];
            2'd1:    top = result[WORD_W-1];
            default: top = result[DATA_W-1];
        endcase
    end

    assign flags.n = top;
    assign flags.z = ((result & mask) == '0);
    assign flags.v = lane_v[sel];
    assign flags.c = lane_c[sel];
    assign flags.x = lane_x[sel];

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_opnd,
    input  logic [1:0]        req_size,
    input  logic [CNT_W-1:0]  req_count,
    input  logic [2:0]        req_op,
    input  logic              req_xflag,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_result,
    output logic              rsp_n,
    output logic              rsp_z,
    output logic              rsp_v,
    output logic              rsp_c,
    output logic              rsp_x
);
    logic [NUM_LANES-1:0][DATA_W-1:0] lane_res;
    logic [NUM_LANES-1:0]             lane_c;
    logic [NUM_LANES-1:0]             lane_x;
    logic [NUM_LANES-1:0]             lane_v;

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW = DATA_W >> (NUM_LANES - 1 - g);
        logic [LW-1:0] res_g;
        shrot_lane #(.W(LW), .CNT_W(CNT_W)) i_lane (
            .opnd  (req_opnd[LW-1:0]),
            .count (req_count),
            .op    (req_op),
            .xin   (req_xflag),
            .res   (res_g),
            .c_out (lane_c[g]),
            .x_out (lane_x[g]),
            .v_out (lane_v[g])
        );
        assign lane_res[g] = DATA_W'(res_g);
    end

    logic [DATA_W-1:0] nxt_result;
    shr_flags_t        nxt_flags;

    shrot_merge #(.DATA_W(DATA_W)) i_merge (
        .size     (req_size),
        .opnd     (req_opnd),
        .lane_res (lane_res),
        .lane_c   (lane_c),
        .lane_x   (lane_x),
        .lane_v   (lane_v),
        .result   (nxt_result),
        .flags    (nxt_flags)
    );

    shr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid)  state_d = ST_LOADED;
            ST_LOADED: if (!req_valid) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    shr_flags_t flags_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_result <= '0;
            flags_q    <= '0;
        end else if (req_valid) begin
            rsp_result <= nxt_result;
            flags_q    <= nxt_flags;
        end
    end

    assign rsp_valid = (state_q == ST_LOADED);
    assign rsp_n     = flags_q.n;
    assign rsp_z     = flags_q.z;
    assign rsp_v     = flags_q.v;
    assign rsp_c     = flags_q.c;
    assign rsp_x     = flags_q.x;

endmodule

// File: rtl/shrot_unit_chk.sv
module shrot_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [31:0] req_opnd,
    input logic [1:0]  req_size,
    input logic [5:0]  req_count,
    input logic [2:0]  req_op,
    input logic        req_xflag,
    input logic        rsp_valid,
    input logic [31:0] rsp_result,
    input logic        rsp_n,
    input logic        rsp_z,
    input logic        rsp_v,
    input logic        rsp_c,
    input logic        rsp_x
);
    p_valid_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && $stable(rsp_result) && $stable(rsp_c) && $stable(rsp_x)));

    p_byte_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b00) |=> (rsp_result[31:8] == $past(req_opnd[31:8])));

    p_word_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b01) |=> (rsp_result[31:16] == $past(req_opnd[31:16])));

    p_v_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != 3'b010) |=> !rsp_v);

    p_zero_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_op[2] && req_count == 6'd0) |=> (!rsp_c && rsp_x == $past(req_xflag)));

    p_rot_keeps_x_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op[2:1] == 2'b10) |=> (rsp_x == $past(req_xflag)));

    p_ring_cx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op[2:1] == 2'b11) |=> (rsp_c == rsp_x));

    p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'b00) |=> (rsp_z == (rsp_result[7:0] == 8'd0) && rsp_n == rsp_result[7]));

endmodule

bind shrot_unit shrot_unit_chk i_chk (.*);

// File: tb/test_shrot_unit.sv
`timescale 1ns/1ps
module test_shrot_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_opnd;
    logic [1:0]  req_size;
    logic [5:0]  req_count;
    logic [2:0]  req_op;
    logic        req_xflag;
    logic        rsp_valid;
    logic [31:0] rsp_result;
    logic        rsp_n, rsp_z, rsp_v, rsp_c, rsp_x;

    always #2.5 clk = ~clk;

    shrot_unit i_shrot_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opnd(req_opnd),
        .req_size(req_size), .req_count(req_count), .req_op(req_op), .req_xflag(req_xflag),
        .rsp_valid(rsp_valid), .rsp_result(rsp_result), .rsp_n(rsp_n), .rsp_z(rsp_z),
        .rsp_v(rsp_v), .rsp_c(rsp_c), .rsp_x(rsp_x)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    logic [31:0] exp_res;
    logic [4:0]  exp_fl;   // {n,z,v,c,x}

    // step-by-step reference model
    task automatic model(input logic [2:0] op, input logic [1:0] sz, input int cnt,
                         input logic [31:0] opnd, input logic xin,
                         output logic [31:0] res, output logic [4:0] fl);
        int w;
        logic [63:0] v, mask;
        logic c, x, ov, outb, msb;
        w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        mask = (64'd1 << w) - 64'd1;
        v = {32'd0, opnd} & mask;
        c = 1'b0; x = xin; ov = 1'b0;
        for (int i = 0; i < cnt; i++) begin
            msb = v[w-1];
            case (op)
                3'd0, 3'd2: begin outb = msb; v = (v << 1) & mask; c = outb; x = outb;
                                  if (op == 3'd2 && v[w-1] != msb) ov = 1'b1; end
                3'd1: begin outb = v[0]; v = v >> 1; c = outb; x = outb; end
                3'd3: begin outb = v[0]; v = (v >> 1) | ({63'd0, msb} << (w-1)); c = outb; x = outb; end
                3'd4: begin outb = msb; v = ((v << 1) | {63'd0, outb}) & mask; c = outb; end
                3'd5: begin outb = v[0]; v = (v >> 1) | ({63'd0, outb} << (w-1)); c = outb; end
                3'd6: begin outb = msb; v = ((v << 1) | {63'd0, x}) & mask; x = outb; end
                default: begin outb = v[0]; v = (v >> 1) | ({63'd0, x} << (w-1)); x = outb; end
            endcase
        end
        if (op[2:1] == 2'b11) c = x;
        res = (opnd & ~mask[31:0]) | v[31:0];
        fl = {v[w-1], (v == 64'd0), ov, c, x};
    endtask

    task automatic step(input logic vld, input logic [2:0] op, input logic [1:0] sz,
                        input logic [5:0] cnt, input logic [31:0] opnd, input logic xin,
                        input string tag);
        logic [4:0] got;
        @(negedge clk);
        req_valid = vld; req_op = op; req_size = sz; req_count = cnt;
        req_opnd = opnd; req_xflag = xin;
        if (vld) model(op, sz, int'(cnt), opnd, xin, exp_res, exp_fl);
        @(negedge clk);
        got = {rsp_n, rsp_z, rsp_v, rsp_c, rsp_x};
        n_checks++;
        if (rsp_valid !== vld || rsp_result !== exp_res || got !== exp_fl) begin
            n_fails++;
            $display("FAIL %s op=%0d sz=%0d cnt=%0d opnd=%h x=%b: got valid=%b res=%h nzvcx=%b, exp valid=%b res=%h nzvcx=%b",
                     tag, op, sz, cnt, opnd, xin, rsp_valid, rsp_result, got, vld, exp_res, exp_fl);
        end
        req_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_opnd = '0; req_size = '0;
        req_count = '0; req_op = '0; req_xflag = 1'b0;
        exp_res = '0; exp_fl = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        n_checks++;
        if (rsp_valid !== 1'b0 || rsp_result !== 32'd0 || {rsp_n, rsp_z, rsp_v, rsp_c, rsp_x} !== 5'd0) begin
            n_fails++;
            $display("FAIL R1 reset: got valid=%b res=%h, exp valid=0 res=0", rsp_valid, rsp_result);
        end

        // R1: capture then hold
        step(1, 3'd0, 2'b10, 6'd4, 32'h1234_5678, 1'b0, "R1 load");
        step(0, 3'd1, 2'b00, 6'd7, 32'hFFFF_FFFF, 1'b1, "R1 hold");
        step(0, 3'd4, 2'b01, 6'd3, 32'h0000_0001, 1'b0, "R1 hold2");
        // R2: sizes and pass-through of upper bits
        step(1, 3'd0, 2'b00, 6'd3, 32'hA5C3_E781, 1'b0, "R2 byte");
        step(1, 3'd1, 2'b01, 6'd5, 32'hDEAD_BEEF, 1'b1, "R2 word");
        step(1, 3'd4, 2'b11, 6'd8, 32'h8000_0001, 1'b0, "R2 size11");
        // R3: zero fill and long counts
        step(1, 3'd1, 2'b10, 6'd40, 32'hFFFF_FFFF, 1'b1, "R3 lsr40");
        step(1, 3'd0, 2'b00, 6'd8, 32'h0000_00FF, 1'b0, "R3 lsl8");
        step(1, 3'd1, 2'b00, 6'd9, 32'h0000_0080, 1'b1, "R3 lsr9");
        // R4: sign replication
        step(1, 3'd3, 2'b01, 6'd20, 32'h0000_8000, 1'b0, "R4 asr20");
        step(1, 3'd3, 2'b00, 6'd3, 32'h0000_0096, 1'b0, "R4 asr3");
        step(1, 3'd3, 2'b10, 6'd31, 32'h4000_0000, 1'b1, "R4 asr31pos");
        // R5: overflow of left arithmetic shift
        step(1, 3'd2, 2'b00, 6'd1, 32'h0000_0040, 1'b0, "R5 asl flip");
        step(1, 3'd2, 2'b00, 6'd1, 32'h0000_00C0, 1'b0, "R5 asl noflip");
        step(1, 3'd2, 2'b00, 6'd6, 32'h0000_0001, 1'b0, "R5 asl late");
        step(1, 3'd2, 2'b00, 6'd8, 32'h0000_00FF, 1'b0, "R5 asl ones8");
        step(1, 3'd2, 2'b01, 6'd63, 32'h0000_0001, 1'b0, "R5 asl far");
        step(1, 3'd2, 2'b10, 6'd0, 32'h4000_0000, 1'b1, "R5 asl zero");
        // R6: count zero and last bit out
        step(1, 3'd0, 2'b10, 6'd0, 32'h8000_0000, 1'b1, "R6 cnt0 x1");
        step(1, 3'd1, 2'b01, 6'd0, 32'h0000_0001, 1'b0, "R6 cnt0 x0");
        step(1, 3'd0, 2'b01, 6'd16, 32'h0000_0001, 1'b0, "R6 lsl16");
        // R7: plain rotates
        step(1, 3'd4, 2'b01, 6'd4, 32'h5555_8001, 1'b1, "R7 rol");
        step(1, 3'd5, 2'b00, 6'd1, 32'h0000_0001, 1'b0, "R7 ror");
        step(1, 3'd5, 2'b10, 6'd0, 32'h8000_0001, 1'b1, "R7 ror0");
        step(1, 3'd4, 2'b00, 6'd16, 32'h0000_0081, 0, "R7 rol16");
        // R8: rotate through extend
        step(1, 3'd6, 2'b00, 6'd9, 32'h0000_005A, 1'b1, "R8 rxl9");
        step(1, 3'd6, 2'b00, 6'd1, 32'h0000_0080, 1'b0, "R8 rxl1");
        step(1, 3'd7, 2'b00, 6'd1, 32'h0000_0000, 1'b1, "R8 rxr1");
        step(1, 3'd7, 2'b01, 6'd0, 32'h0000_1234, 1'b1, "R8 rxr0");
        // R9: N and Z on the sized part only
        step(1, 3'd0, 2'b00, 6'd1, 32'hFFFF_FF80, 1'b0, "R9 zero byte");
        step(1, 3'd1, 2'b01, 6'd0, 32'h0000_8000, 1'b0, "R9 neg word");
        // R10: counts that wrap the ring several times
        step(1, 3'd6, 2'b00, 6'd18, 32'h0000_00C3, 1'b0, "R10 rxl18");
        step(1, 3'd7, 2'b00, 6'd63, 32'h0000_0035, 1'b1, "R10 rxr63");
        step(1, 3'd7, 2'b10, 6'd34, 32'h8765_4321, 1'b1, "R10 rxr34");
        step(1, 3'd5, 2'b01, 6'd63, 32'hF00F_0F0F, 1'b0, "R10 ror63");

        // mixed random traffic with gaps
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) != 0, 3'($urandom), 2'($urandom), 6'($urandom),
                 $urandom, 1'($urandom), "R10 random");
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule